// File: doc/BRIEF.md
# Request-Response Transport Checker

This block is a synthesizable monitor placed across a unit that accepts tagged requests and later returns tagged responses. It watches the request and response traffic without influencing it. It raises a sticky error flag whenever the unit fails to carry a transaction faithfully. The faults it detects are:

- a response that never arrives or arrives too late;
- a response stream that stalls;
- a response that repeats one already delivered;
- a response nobody asked for;
- an ordered request answered out of turn;
- too many transactions in flight;
- beats of two response bursts mixed together.

Each ID can carry at most one outstanding transaction. A request with `req_inorder` set joins an ordered class: members of that class must be answered in the order they were issued. Requests without the qualifier may be answered in any order. A response may span several beats on `rsp_valid`. The final beat carries `rsp_last`, and that beat retires the transaction.

Within one cycle, the response side is evaluated before the request side. A request and a response in the same cycle therefore see the table as it stood before that request.

Top module: `tc_transport_checker`

## Requirements
- R1: After reset `err_flags` is all zero. Once a bit of `err_flags` is set, it stays set until the next reset. The bit positions are: 0 late, 1 stall, 2 duplicate, 3 unrequested, 4 order, 5 overflow, 6 interleave.
- R2: Bit 0 sets when a transaction has stayed outstanding for more than MAX_LAT cycles without its final beat.
- R3: Bit 1 sets when MAX_GAP consecutive cycles pass with at least one transaction outstanding and no response beat.
- R4: Bit 2 sets when a response starts for an ID that is not outstanding but whose previous transaction has already completed.
- R5: Bit 3 sets when a response starts for an ID that has never been requested since reset and is not outstanding. A request raised in the same cycle as that response does not count.
- R6: Bit 4 sets when a response starts for an ordered transaction that is not the oldest ordered transaction still unanswered. Unordered transactions may complete in any order without setting it.
- R7: Bit 5 sets when a request would bring the outstanding count above MAX_OUT. A transaction retired in the same cycle is subtracted first.
- R8: Bit 6 sets when a beat for a different ID arrives while a burst is open. A burst opens on a non-final beat and closes on the beat with `rsp_last`.
- R9: Traffic that obeys all the rules, including re-use of an ID after its transaction completes, sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is issued this cycle |
| req_id | input | ID_W | Tag of the request |
| req_inorder | input | 1 | Request belongs to the ordered class |
| rsp_valid | input | 1 | A response beat is present this cycle |
| rsp_id | input | ID_W | Tag of the response beat |
| rsp_last | input | 1 | Final beat of the response |
| err_flags | output | 7 | Sticky violation flags, positions as in R1 |

## Verification
The interesting collisions are a request and a retiring response in the same cycle. This case decides both the outstanding count (R7) and whether a same-tag response counts as unrequested (R5). The bench fills the table to exactly MAX_OUT and then issues a new request together with a final beat. It expects no overflow there, and an overflow one request later. It also drives a request and a final beat on one tag in a single cycle, and expects the unrequested flag because responses are judged first. A scoreboard queue holds the expected flag vector for each scenario, and a monitor compares it one cycle after the last stimulus.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
    localparam int NUM_ERR   = 7;
    localparam int ERR_LATE  = 0;
    localparam int ERR_GAP   = 1;
    localparam int ERR_DUP   = 2;
    localparam int ERR_EXTRA = 3;
    localparam int ERR_ORDER = 4;
    localparam int ERR_OVER  = 5;
    localparam int ERR_ILV   = 6;
endpackage

// File: rtl/tc_age_table.sv
`timescale 1ns/1ps
// Per-ID outstanding table: valid, ordered class, completed marker and age.
module tc_age_table #(
    parameter int ID_W    = 3,
    parameter int MAX_LAT = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic [ID_W-1:0]      alloc_id,
    input  logic                 alloc_ord,
    input  logic                 free_en,
    input  logic [ID_W-1:0]      free_id,
    output logic [(1<<ID_W)-1:0] valid_o,
    output logic [(1<<ID_W)-1:0] ord_o,
    output logic [(1<<ID_W)-1:0] done_o,
    output logic                 late_o
);
    localparam int NUM_ID = 1 << ID_W;
    localparam int AGE_W  = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic             valid;
        logic             ord;
        logic             done;
        logic [AGE_W-1:0] age;
    } ent_t;

    logic [NUM_ID-1:0] late_vec;

    for (genvar i = 0; i < NUM_ID; i++) begin : g_ent
        ent_t e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (e_q.valid && (e_q.age < AGE_W'(MAX_LAT))) begin
                e_d.age = e_q.age + 1'b1;
            end
            if (free_en && (free_id == ID_W'(i))) begin
                e_d.valid = 1'b0;
                e_d.done  = 1'b1;
            end
            if (alloc_en && (alloc_id == ID_W'(i))) begin
                e_d.valid = 1'b1;
                e_d.ord   = alloc_ord;
                e_d.done  = 1'b0;
                e_d.age   = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) e_q <= '0;
            else        e_q <= e_d;
        end

        assign valid_o[i]  = e_q.valid;
        assign ord_o[i]    = e_q.ord;
        assign done_o[i]   = e_q.done;
        assign late_vec[i] = e_q.valid && (e_q.age == AGE_W'(MAX_LAT));
    end

    assign late_o = |late_vec;
endmodule

// File: rtl/tc_order_fifo.sv
`timescale 1ns/1ps
// FIFO of tags belonging to the ordered class, oldest at the head.
module tc_order_fifo #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_o,
    output logic            empty_o
);
    localparam int DEPTH = 1 << ID_W;
    localparam int CW    = ID_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] mem;
        logic [ID_W-1:0]            wp;
        logic [ID_W-1:0]            rp;
        logic [CW-1:0]              cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && (f_q.cnt != CW'(DEPTH));
        if (do_push) begin
            f_d.mem[f_q.wp] = push_id;
            f_d.wp          = f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = f_q.rp + 1'b1;
        end
        f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_o  = f_q.mem[f_q.rp];
    assign empty_o = (f_q.cnt == '0);
endmodule

// File: rtl/tc_gap_timer.sv
`timescale 1ns/1ps
// Counts consecutive busy cycles without a response beat.
module tc_gap_timer #(
    parameter int MAX_GAP = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic beat,
    output logic expired_o
);
    localparam int GW = $clog2(MAX_GAP + 1);

    logic [GW-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (beat || !busy)                  gap_d = '0;
        else if (gap_q < GW'(MAX_GAP))      gap_d = gap_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign expired_o = (gap_q == GW'(MAX_GAP));
endmodule

// File: rtl/tc_transport_checker.sv
`timescale 1ns/1ps
module tc_transport_checker
    import tc_pkg::*;
#(
    parameter int ID_W    = 3,
    parameter int MAX_OUT = 6,
    parameter int MAX_LAT = 40,
    parameter int MAX_GAP = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ID_W-1:0]    req_id,
    input  logic               req_inorder,
    input  logic               rsp_valid,
    input  logic [ID_W-1:0]    rsp_id,
    input  logic               rsp_last,
    output logic [NUM_ERR-1:0] err_flags
);
    localparam int NUM_ID = 1 << ID_W;
    localparam int CNT_W  = $clog2(NUM_ID + 1);

    typedef struct packed {
        logic               lock;
        logic [ID_W-1:0]    lock_id;
        logic [CNT_W-1:0]   cnt;
        logic [NUM_ERR-1:0] err;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_ID-1:0] valid_vec, ord_vec, done_vec;
    logic              late, gap_exp;
    logic [ID_W-1:0]   fifo_head;
    logic              fifo_empty;
    logic              first, cont, ilv, dup, extra, ord_bad, over;
    logic              release_en, alloc_en, pop_en, push_en;
    logic [CNT_W-1:0]  cnt_after_rel;

    always_comb begin
        s_d        = s_q;
        first      = rsp_valid && !s_q.lock;
        cont       = rsp_valid && s_q.lock && (rsp_id == s_q.lock_id);
        ilv        = rsp_valid && s_q.lock && (rsp_id != s_q.lock_id);
        dup        = first && !valid_vec[rsp_id] && done_vec[rsp_id];
        extra      = first && !valid_vec[rsp_id] && !done_vec[rsp_id];
        ord_bad    = first && valid_vec[rsp_id] && ord_vec[rsp_id]
                     && (fifo_empty || (fifo_head != rsp_id));
        release_en = rsp_valid && rsp_last && valid_vec[rsp_id] && (first || cont);
        pop_en     = release_en && ord_vec[rsp_id];
        alloc_en   = req_valid
                     && (!valid_vec[req_id] || (release_en && (rsp_id == req_id)));
        push_en    = alloc_en && req_inorder;

        cnt_after_rel = s_q.cnt - CNT_W'(release_en);
        over          = req_valid && (cnt_after_rel >= CNT_W'(MAX_OUT));
        s_d.cnt       = cnt_after_rel + CNT_W'(alloc_en);

        if (release_en) begin
            s_d.lock = 1'b0;
        end else if (first && valid_vec[rsp_id] && !rsp_last) begin
            s_d.lock    = 1'b1;
            s_d.lock_id = rsp_id;
        end

        s_d.err[ERR_LATE]  = s_q.err[ERR_LATE]  | late;
        s_d.err[ERR_GAP]   = s_q.err[ERR_GAP]   | gap_exp;
        s_d.err[ERR_DUP]   = s_q.err[ERR_DUP]   | dup;
        s_d.err[ERR_EXTRA] = s_q.err[ERR_EXTRA] | extra;
        s_d.err[ERR_ORDER] = s_q.err[ERR_ORDER] | ord_bad;
        s_d.err[ERR_OVER]  = s_q.err[ERR_OVER]  | over;
        s_d.err[ERR_ILV]   = s_q.err[ERR_ILV]   | ilv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    tc_age_table #(.ID_W(ID_W), .MAX_LAT(MAX_LAT)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_id  (req_id),
        .alloc_ord (req_inorder),
        .free_en   (release_en),
        .free_id   (rsp_id),
        .valid_o   (valid_vec),
        .ord_o     (ord_vec),
        .done_o    (done_vec),
        .late_o    (late)
    );

    tc_order_fifo #(.ID_W(ID_W)) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_en),
        .push_id (req_id),
        .pop     (pop_en),
        .head_o  (fifo_head),
        .empty_o (fifo_empty)
    );

    tc_gap_timer #(.MAX_GAP(MAX_GAP)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (s_q.cnt != '0),
        .beat      (rsp_valid),
        .expired_o (gap_exp)
    );

    logic              lock_q;
    logic [ID_W-1:0]   lock_id_q;
    logic [CNT_W-1:0]  cnt_q;
    assign lock_q    = s_q.lock;
    assign lock_id_q = s_q.lock_id;
    assign cnt_q     = s_q.cnt;
    assign err_flags = s_q.err;
endmodule

// File: rtl/tc_transport_checker_sva.sv
`timescale 1ns/1ps
module tc_transport_checker_sva
    import tc_pkg::*;
#(
    parameter int ID_W    = 3,
    parameter int MAX_OUT = 6,
    parameter int CNT_W   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rsp_valid,
    input logic [ID_W-1:0]      rsp_id,
    input logic                 rsp_last,
    input logic [NUM_ERR-1:0]   err_flags,
    input logic                 lock_q,
    input logic [ID_W-1:0]      lock_id_q,
    input logic [CNT_W-1:0]     cnt_q,
    input logic [(1<<ID_W)-1:0] valid_vec,
    input logic [(1<<ID_W)-1:0] done_vec
);
    // R1
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R7
    outstanding_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CNT_W'(MAX_OUT)) |-> err_flags[ERR_OVER]);

    // R8
    interleave_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lock_q && (rsp_id != lock_id_q)) |=> err_flags[ERR_ILV]);

    // R8
    burst_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last && lock_q && (rsp_id == lock_id_q)) |=> !lock_q);

    // R5
    unrequested_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !lock_q && !valid_vec[rsp_id] && !done_vec[rsp_id])
        |=> err_flags[ERR_EXTRA]);
endmodule

bind tc_transport_checker tc_transport_checker_sva #(
    .ID_W(ID_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .rsp_last  (rsp_last),
    .err_flags (err_flags),
    .lock_q    (lock_q),
    .lock_id_q (lock_id_q),
    .cnt_q     (cnt_q),
    .valid_vec (valid_vec),
    .done_vec  (done_vec)
);

// File: tb/sim_tc_transport_checker.sv
`timescale 1ns/1ps
module sim_tc_transport_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_id = '0;
    logic       req_inorder = 1'b0;
    logic       rsp_valid = 1'b0;
    logic [2:0] rsp_id = '0;
    logic       rsp_last = 1'b0;
    logic [6:0] err_flags;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [6:0] exp_vec[$];
    string      exp_tag[$];

    always #4 clk = ~clk;

    tc_transport_checker #(.ID_W(3), .MAX_OUT(6), .MAX_LAT(40), .MAX_GAP(20)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_id(req_id), .req_inorder(req_inorder),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_last(rsp_last),
        .err_flags(err_flags)
    );

    task automatic drive(input logic rv, input logic [2:0] rid, input logic ro,
                         input logic sv, input logic [2:0] sid, input logic sl);
        req_valid = rv; req_id = rid; req_inorder = ro;
        rsp_valid = sv; rsp_id = sid; rsp_last = sl;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic req(input logic [2:0] id, input logic ord);
        drive(1, id, ord, 0, 0, 0);
    endtask

    task automatic rsp(input logic [2:0] id, input logic last);
        drive(0, 0, 0, 1, id, last);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic expect_flags(input logic [6:0] v, input string tag);
        idle(1);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
        wait (exp_vec.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: compares queued expectations away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_vec.size() != 0) begin
                logic [6:0] v;
                string      t;
                v = exp_vec.pop_front();
                t = exp_tag.pop_front();
                checks++;
                if (err_flags !== v) begin
                    fails++;
                    $display("FAIL %s actual=%b expected=%b", t, err_flags, v);
                end
            end
        end
    end

    initial begin
        #(64'd8 * 64'd200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        expect_flags(7'b0000000, "R1 reset state");

        // R9, R6: mixed ordered/unordered traffic, one two-beat burst
        req(1, 1); req(2, 0); req(3, 1); req(4, 0);
        rsp(2, 1); rsp(1, 0); rsp(1, 1); rsp(4, 1); rsp(3, 1);
        expect_flags(7'b0000000, "R9 R6 legal mixed traffic");

        // R9: tag reuse after completion
        do_reset();
        req(2, 0); rsp(2, 1); req(2, 0); rsp(2, 1);
        expect_flags(7'b0000000, "R9 tag reuse");

        // R7: table at MAX_OUT, new request alongside a retiring beat
        do_reset();
        for (int i = 0; i < 6; i++) req(3'(i), 0);
        drive(1, 6, 0, 1, 0, 1);
        expect_flags(7'b0000000, "R7 same-cycle retire at limit");
        req(7, 0);
        expect_flags(7'b0100000, "R7 overflow");

        // R4 and R1 stickiness
        do_reset();
        req(2, 0); rsp(2, 1); rsp(2, 1);
        expect_flags(7'b0000100, "R4 duplicate");
        idle(5);
        expect_flags(7'b0000100, "R1 sticky");

        // R5: never requested
        do_reset();
        rsp(5, 1);
        expect_flags(7'b0001000, "R5 unrequested");

        // R5: request in the same cycle does not cover the response
        do_reset();
        drive(1, 4, 0, 1, 4, 1);
        expect_flags(7'b0001000, "R5 same-cycle request");

        // R6: ordered out of turn
        do_reset();
        req(1, 1); req(3, 1); rsp(3, 1);
        expect_flags(7'b0010000, "R6 order");

        // R8: interleaved burst
        do_reset();
        req(1, 0); req(2, 0); rsp(1, 0); rsp(2, 1);
        expect_flags(7'b1000000, "R8 interleave");

        // R3: stall beyond MAX_GAP
        do_reset();
        req(1, 0); idle(25); rsp(1, 1);
        expect_flags(7'b0000010, "R3 stall");

        // R3: short stall is fine
        do_reset();
        req(1, 0); idle(10); rsp(1, 1);
        expect_flags(7'b0000000, "R3 short gap");

        // R2: tag 0 starves while tag 1 streams a long burst
        do_reset();
        req(0, 0); req(1, 0);
        for (int i = 0; i < 45; i++) rsp(1, 0);
        rsp(1, 1);
        expect_flags(7'b0000001, "R2 late");

        // R2: within the latency limit
        do_reset();
        req(0, 0); req(1, 0);
        for (int i = 0; i < 30; i++) rsp(1, 0);
        rsp(1, 1); rsp(0, 1);
        expect_flags(7'b0000000, "R2 within limit");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule